// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a configuration-space controller placed behind a simple host I/O bus with an address, write data, read data and separate read and write strobes. Two pins of the I/O space act as a register window: the lower one (the index port) selects a register number, and the one directly above it (the data port) reads or writes the register selected. Strap inputs choose which address pair is used and which 8-bit unlock key applies.

The register window is closed after reset. Host software opens it by writing the key to the index port on two consecutive writes, and closes it again with a fixed exit code. Once the window is open, some registers are global (device identification, clock selection, logical device number). Others are banked per logical device, and the device-number register picks the bank. The banked enable and FIFO-mode values of every device, and the global clock selection, are driven out as parallel outputs for the serial channels that consume them.

Top module: `cfgport_top`

## Requirements
- R1: The port strap selects the address pair: strap 0 gives index 0x4E and data 0x4F, strap 1 gives index 0x2E and data 0x2F. The straps are captured on the first clock after reset is released and hold their captured values until the next reset. Before capture, the defaults (port strap 1, key straps 11) apply.
- R2: The key straps {K1,K0} select the unlock key as follows: 00 selects 0x77, 01 selects 0xA0, 10 selects 0x87 and 11 selects 0x67.
- R3: The window opens only after two consecutive bus writes of the key to the index port. Idle cycles and reads may lie between them. cfgUnlocked is high from the cycle after the second write.
- R4: While the window is closed, any other write in between breaks the sequence and restarts the key count. This includes a non-key write to the index port and a write to any other address.
- R5: While the window is closed, data-port writes change no register or output, and reads of the index or data port return 0xFF.
- R6: While the window is open, writing 0xAA to the index port closes it from the next cycle. The latched index keeps its previous value.
- R7: While the window is open, any other index-port write latches a register number. Index-port reads return it, and data-port accesses reach that register.
- R8: Index 0x20 reads the identification high byte (default 0x5A) and index 0x21 reads the low byte (default 0xC3). Writes to them are ignored.
- R9: Index 0x25 is a global read/write clock-select byte driven on clkSel, with reset value 0x00. Value 1 selects the 48 MHz input.
- R10: Index 0x07 is a read/write device-number byte with reset value 0. The banked registers are index 0x30 (enable in bit 0, read back as {7'b0,enable}) and index 0xF6 (FIFO-mode byte; 3 selects 128-byte FIFOs with standard receive triggers). Both reach the bank of devices 0 to 3. For a device number of 4 or above, banked reads return 0x00 and banked writes are ignored.
- R11: In the open window, every other index reads 0x00 and ignores writes.
- R12: devEnable[d] and devFifoMode[8d+7:8d] show device d's bank. Both reset to 0.
- R13: ioRdData is valid in the same cycle as ioRd. When a write occurs in the same cycle, the read shows the state before that write. Reads of addresses other than the two ports, or with ioRd low, return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapPortSel | input | 1 | Address-pair strap |
| strapKey | input | 2 | Unlock-key straps {K1,K0} |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWrData | input | 8 | Host write data |
| ioWr | input | 1 | Write strobe, one access per cycle |
| ioRd | input | 1 | Read strobe |
| ioRdData | output | 8 | Read data, combinational |
| cfgUnlocked | output | 1 | Register window open |
| clkSel | output | 8 | Global clock-select value |
| devEnable | output | NDEV | Per-device enable bits |
| devFifoMode | output | 8*NDEV | Per-device FIFO-mode bytes |

## Verification
Because ioRdData is combinational and the registers update on the clock edge, a read and a write on the same port can land in the same cycle. The bench provokes three cases of this. First, it writes the second key byte while reading the index port; the read must still return 0xFF. Second, it writes the exit code while reading the index port; the read must still return the latched index. Third, it writes a data-port register while reading it; the read must return the old value, and only a following read shows the new one.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef struct packed {
    logic       regWr;
    logic [7:0] regIdx;
    logic [7:0] wrData;
  } cfgStrobe_t;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } lockState_t;

  localparam logic [7:0] EXIT_CODE    = 8'hAA;
  localparam logic [7:0] IDX_DEVNUM   = 8'h07;
  localparam logic [7:0] IDX_ID_HI    = 8'h20;
  localparam logic [7:0] IDX_ID_LO    = 8'h21;
  localparam logic [7:0] IDX_CLKSEL   = 8'h25;
  localparam logic [7:0] IDX_ENABLE   = 8'h30;
  localparam logic [7:0] IDX_FIFOMODE = 8'hF6;

  function automatic logic [7:0] keyFromStrap(input logic [1:0] sel);
    case (sel)
      2'b00:   keyFromStrap = 8'h77;
      2'b01:   keyFromStrap = 8'hA0;
      2'b10:   keyFromStrap = 8'h87;
      default: keyFromStrap = 8'h67;
    endcase
  endfunction

endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPortSel,
  input  logic [1:0]        strapKey,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [7:0]        regRdData,
  output cfgStrobe_t        strobe,
  output logic [7:0]        ioRdData,
  output logic              cfgUnlocked,
  output logic [ADDR_W-1:0] idxAddr,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [7:0]        keyByte
);

  localparam logic [ADDR_W-1:0] IDX_PAIR1 = ADDR_W'('h2E);
  localparam logic [ADDR_W-1:0] IDX_PAIR0 = ADDR_W'('h4E);

  logic       strapDone;
  logic       portSelQ;
  logic [1:0] keySelQ;
  lockState_t state;
  logic [7:0] idxQ;
  logic       hitIdx;
  logic       hitData;
  logic       isKey;

  // straps captured once, on the first clock after reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapDone <= 1'b0;
      portSelQ  <= 1'b1;
      keySelQ   <= 2'b11;
    end else if (!strapDone) begin
      strapDone <= 1'b1;
      portSelQ  <= strapPortSel;
      keySelQ   <= strapKey;
    end
  end

  assign idxAddr  = portSelQ ? IDX_PAIR1 : IDX_PAIR0;
  assign dataAddr = idxAddr + ADDR_W'(1);
  assign keyByte  = keyFromStrap(keySelQ);

  assign hitIdx  = (ioAddr == idxAddr);
  assign hitData = (ioAddr == dataAddr);
  assign isKey   = hitIdx && (ioWrData == keyByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOCKED;
      idxQ  <= 8'h00;
    end else if (ioWr) begin
      case (state)
        ST_LOCKED: if (isKey) state <= ST_HALF;
        ST_HALF:   state <= isKey ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (hitIdx) begin
            if (ioWrData == EXIT_CODE) state <= ST_LOCKED;
            else                       idxQ  <= ioWrData;
          end
        end
        default:   state <= ST_LOCKED;
      endcase
    end
  end

  assign cfgUnlocked = (state == ST_OPEN);

  always_comb begin
    strobe.regWr  = ioWr && hitData && cfgUnlocked;
    strobe.regIdx = idxQ;
    strobe.wrData = ioWrData;
  end

  always_comb begin
    ioRdData = 8'hFF;
    if (ioRd && cfgUnlocked) begin
      if (hitIdx)       ioRdData = idxQ;
      else if (hitData) ioRdData = regRdData;
    end
  end

endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int         NDEV  = 4,
  parameter logic [7:0] ID_HI = 8'h5A,
  parameter logic [7:0] ID_LO = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  output logic [7:0]        regRdData,
  output logic [7:0]        clkSel,
  output logic [NDEV-1:0]   devEnable,
  output logic [8*NDEV-1:0] devFifoMode
);

  localparam int         SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [7:0] NDEV_B = 8'(NDEV);

  logic [7:0]       devNumQ;
  logic [7:0]       clkSelQ;
  logic [NDEV-1:0]  enQ;
  logic [7:0]       fifoQ [NDEV];
  logic             bankValid;
  logic [SEL_W-1:0] bankSel;

  assign bankValid = (devNumQ < NDEV_B);
  assign bankSel   = devNumQ[SEL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devNumQ <= 8'h00;
      clkSelQ <= 8'h00;
    end else if (strobe.regWr) begin
      if (strobe.regIdx == IDX_DEVNUM) devNumQ <= strobe.wrData;
      if (strobe.regIdx == IDX_CLKSEL) clkSelQ <= strobe.wrData;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_bank
    logic bankWr;
    assign bankWr = strobe.regWr && bankValid && (bankSel == SEL_W'(d));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[d]   <= 1'b0;
        fifoQ[d] <= 8'h00;
      end else if (bankWr) begin
        if (strobe.regIdx == IDX_ENABLE)   enQ[d]   <= strobe.wrData[0];
        if (strobe.regIdx == IDX_FIFOMODE) fifoQ[d] <= strobe.wrData;
      end
    end

    assign devFifoMode[8*d +: 8] = fifoQ[d];
  end

  assign devEnable = enQ;
  assign clkSel    = clkSelQ;

  always_comb begin
    regRdData = 8'h00;
    case (strobe.regIdx)
      IDX_DEVNUM:   regRdData = devNumQ;
      IDX_ID_HI:    regRdData = ID_HI;
      IDX_ID_LO:    regRdData = ID_LO;
      IDX_CLKSEL:   regRdData = clkSelQ;
      IDX_ENABLE:   if (bankValid) regRdData = {7'b0, enQ[bankSel]};
      IDX_FIFOMODE: if (bankValid) regRdData = fifoQ[bankSel];
      default:      regRdData = 8'h00;
    endcase
  end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         NDEV   = 4,
  parameter logic [7:0] ID_HI  = 8'h5A,
  parameter logic [7:0] ID_LO  = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPortSel,
  input  logic [1:0]        strapKey,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              ioWr,
  input  logic              ioRd,
  output logic [7:0]        ioRdData,
  output logic              cfgUnlocked,
  output logic [7:0]        clkSel,
  output logic [NDEV-1:0]   devEnable,
  output logic [8*NDEV-1:0] devFifoMode
);

  cfgStrobe_t        strobe;
  logic [7:0]        regRdData;
  logic [ADDR_W-1:0] idxAddr;
  logic [ADDR_W-1:0] dataAddr;
  logic [7:0]        keyByte;

  cfgport_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .strapPortSel(strapPortSel),
    .strapKey    (strapKey),
    .ioAddr      (ioAddr),
    .ioWrData    (ioWrData),
    .ioWr        (ioWr),
    .ioRd        (ioRd),
    .regRdData   (regRdData),
    .strobe      (strobe),
    .ioRdData    (ioRdData),
    .cfgUnlocked (cfgUnlocked),
    .idxAddr     (idxAddr),
    .dataAddr    (dataAddr),
    .keyByte     (keyByte)
  );

  cfgport_regs #(.NDEV(NDEV), .ID_HI(ID_HI), .ID_LO(ID_LO)) uRegs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regRdData  (regRdData),
    .clkSel     (clkSel),
    .devEnable  (devEnable),
    .devFifoMode(devFifoMode)
  );

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int ADDR_W = 16,
  parameter int NDEV   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [7:0]        ioWrData,
  input logic              ioWr,
  input logic              ioRd,
  input logic [7:0]        ioRdData,
  input logic              cfgUnlocked,
  input logic [7:0]        clkSel,
  input logic [NDEV-1:0]   devEnable,
  input logic [8*NDEV-1:0] devFifoMode,
  input logic [ADDR_W-1:0] idxAddr,
  input logic [ADDR_W-1:0] dataAddr,
  input logic [7:0]        keyByte
);

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !cfgUnlocked) |-> (ioRdData == 8'hFF)); // R5

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgUnlocked) |-> $past(ioWr && ioAddr == idxAddr && ioWrData == keyByte)); // R3

  AST_EXIT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (cfgUnlocked && ioWr && ioAddr == idxAddr && ioWrData == 8'hAA) |=> !cfgUnlocked); // R6

  AST_LOCKED_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgUnlocked && ioWr && ioAddr == dataAddr) |=>
      ($stable(clkSel) && $stable(devEnable) && $stable(devFifoMode))); // R5

  AST_ONE_BANK_PER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(devEnable ^ $past(devEnable)) <= 1); // R10

endmodule

bind cfgport_top cfgport_chk #(.ADDR_W(ADDR_W), .NDEV(NDEV)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .ioAddr     (ioAddr),
  .ioWrData   (ioWrData),
  .ioWr       (ioWr),
  .ioRd       (ioRd),
  .ioRdData   (ioRdData),
  .cfgUnlocked(cfgUnlocked),
  .clkSel     (clkSel),
  .devEnable  (devEnable),
  .devFifoMode(devFifoMode),
  .idxAddr    (idxAddr),
  .dataAddr   (dataAddr),
  .keyByte    (keyByte)
);

// File: tb/tb_cfgport_top.sv
`timescale 1ns/1ps
module tb_cfgport_top;
  localparam int ADDR_W = 16;
  localparam int NDEV   = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN = 1'b0;
  logic              strapPortSel = 1'b1;
  logic [1:0]        strapKey = 2'b11;
  logic [ADDR_W-1:0] ioAddr = '0;
  logic [7:0]        ioWrData = '0;
  logic              ioWr = 1'b0;
  logic              ioRd = 1'b0;
  logic [7:0]        ioRdData;
  logic              cfgUnlocked;
  logic [7:0]        clkSel;
  logic [NDEV-1:0]   devEnable;
  logic [8*NDEV-1:0] devFifoMode;

  cfgport_top #(.ADDR_W(ADDR_W), .NDEV(NDEV)) dut (
    .clk(clk), .rstN(rstN), .strapPortSel(strapPortSel), .strapKey(strapKey),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioWr(ioWr), .ioRd(ioRd),
    .ioRdData(ioRdData), .cfgUnlocked(cfgUnlocked), .clkSel(clkSel),
    .devEnable(devEnable), .devFifoMode(devFifoMode)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [15:0] mIdxA;
  logic [7:0]  mKey;
  logic [7:0]  mLdn, mClk;
  logic        mEn [NDEV];
  logic [7:0]  mFifo [NDEV];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] keyOf(input int k);
    case (k)
      0: return 8'h77;
      1: return 8'hA0;
      2: return 8'h87;
      default: return 8'h67;
    endcase
  endfunction

  function automatic logic [7:0] mRead(input logic [7:0] i);
    case (i)
      8'h07: return mLdn;
      8'h20: return 8'h5A;
      8'h21: return 8'hC3;
      8'h25: return mClk;
      8'h30: return (mLdn < NDEV) ? {7'b0, mEn[mLdn]} : 8'h00;
      8'hF6: return (mLdn < NDEV) ? mFifo[mLdn] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mWrite(input logic [7:0] i, input logic [7:0] d);
    case (i)
      8'h07: mLdn = d;
      8'h25: mClk = d;
      8'h30: if (mLdn < NDEV) mEn[mLdn] = d[0];
      8'hF6: if (mLdn < NDEV) mFifo[mLdn] = d;
      default: ;
    endcase
  endtask

  task automatic doReset(input bit ps, input int ks);
    @(negedge clk);
    rstN = 1'b0; ioWr = 0; ioRd = 0;
    strapPortSel = ps; strapKey = 2'(ks);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    mIdxA = ps ? 16'h2E : 16'h4E;
    mKey = keyOf(ks);
    mLdn = 0; mClk = 0;
    for (int d = 0; d < NDEV; d++) begin mEn[d] = 0; mFifo[d] = 0; end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #1 chk(tag, ioRdData, exp);
    ioRd = 1'b0;
  endtask

  task automatic rdwr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWr = 1'b1; ioRd = 1'b1;
    #1 chk(tag, ioRdData, exp);
    @(negedge clk);
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic chkOutputs(input string tag);
    logic [NDEV-1:0]   expEn;
    logic [8*NDEV-1:0] expFifo;
    for (int d = 0; d < NDEV; d++) begin
      expEn[d] = mEn[d];
      expFifo[8*d +: 8] = mFifo[d];
    end
    chk({tag, " R12 devEnable"}, devEnable, expEn);
    chk({tag, " R12 devFifoMode"}, devFifoMode, expFifo);
    chk({tag, " R9 clkSel"}, clkSel, mClk);
  endtask

  task automatic unlock();
    wr(mIdxA, mKey);
    wr(mIdxA, mKey);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state
    doReset(1, 3);
    chk("R3 reset locked", cfgUnlocked, 0);
    chkOutputs("reset");
    rd(16'h2F, 8'hFF, "R5 locked data read");
    rd(16'h2E, 8'hFF, "R5 locked index read");

    // strap sweep
    for (int ps = 0; ps < 2; ps++) begin
      for (int ks = 0; ks < 4; ks++) begin
        logic [15:0] otherA;
        doReset(ps[0], ks);
        strapPortSel = ~ps[0];           // late strap change must not matter
        strapKey = ~2'(ks);
        otherA = ps[0] ? 16'h4E : 16'h2E;
        wr(otherA, mKey); wr(otherA, mKey);
        chk("R1 other pair stays locked", cfgUnlocked, 0);
        wr(16'h90, 0);
        wr(mIdxA, mKey);
        chk("R3 one key stays locked", cfgUnlocked, 0);
        wr(mIdxA, mKey);
        chk("R2 strap key opens", cfgUnlocked, 1);
        rd(mIdxA + 16'd1, 8'h00, "R1 data port addr");
        wr(mIdxA, 8'hAA);
        chk("R6 exit closes", cfgUnlocked, 0);
      end
    end

    // sequence breaking
    doReset(1, 3);
    wr(mIdxA, mKey); wr(mIdxA, 8'h12); wr(mIdxA, mKey);
    chk("R4 non-key index write breaks", cfgUnlocked, 0);
    wr(16'h80, 0);
    wr(mIdxA, mKey); wr(16'h80, 8'h67); wr(mIdxA, mKey);
    chk("R4 other address write breaks", cfgUnlocked, 0);
    wr(16'h80, 0);
    wr(mIdxA, mKey); wr(16'h2F, 8'h00); wr(mIdxA, mKey);
    chk("R4 data port write breaks", cfgUnlocked, 0);
    wr(16'h80, 0);
    wr(mIdxA, mKey);
    rd(16'h2E, 8'hFF, "R5 read between keys");
    rd(16'h2F, 8'hFF, "R5 read between keys");
    wr(mIdxA, mKey);
    chk("R3 reads do not break", cfgUnlocked, 1);

    // locked write ignored, index kept over exit
    wr(16'h2E, 8'h25); wr(16'h2F, 8'h11); mWrite(8'h25, 8'h11);
    chkOutputs("R9 clksel write");
    wr(16'h2E, 8'hAA);
    wr(16'h2F, 8'h55);
    chkOutputs("R5 locked data write");
    unlock();
    rd(16'h2E, 8'h25, "R6 index kept");
    rd(16'h2F, 8'h11, "R5 value kept");

    // bank sweep, including out-of-range device numbers
    for (int l = 0; l < 6; l++) begin
      wr(16'h2E, 8'h07); wr(16'h2F, 8'(l)); mWrite(8'h07, 8'(l));
      wr(16'h2E, 8'h30); wr(16'h2F, (l % 2) ? 8'h81 : 8'h00); mWrite(8'h30, (l % 2) ? 8'h81 : 8'h00);
      wr(16'h2E, 8'hF6); wr(16'h2F, 8'h10 + 8'(l)); mWrite(8'hF6, 8'h10 + 8'(l));
      chkOutputs("R10 bank write");
    end
    for (int l = 0; l < 6; l++) begin
      wr(16'h2E, 8'h07); wr(16'h2F, 8'(l)); mWrite(8'h07, 8'(l));
      wr(16'h2E, 8'h30); rd(16'h2F, mRead(8'h30), "R10 enable readback");
      wr(16'h2E, 8'hF6); rd(16'h2F, mRead(8'hF6), "R10 fifo readback");
    end
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h01); mWrite(8'h07, 8'h01);

    // full index sweep
    for (int i = 0; i < 256; i++) begin
      if (i != 8'hAA) begin
        wr(16'h2E, 8'(i));
        rd(16'h2E, 8'(i), "R7 index readback");
        wr(16'h2F, 8'(i) ^ 8'h3C);
        mWrite(8'(i), 8'(i) ^ 8'h3C);
        rd(16'h2F, mRead(8'(i)), "R11 R8 R10 data readback");
      end
    end
    chkOutputs("R11 after sweep");
    chk("R3 still open", cfgUnlocked, 1);

    // concurrent read and write (R13)
    rd(16'h80, 8'hFF, "R13 foreign address");
    wr(16'h2E, 8'h25);
    rdwr(16'h2F, 8'h77, mClk, "R13 read shows old value");
    mWrite(8'h25, 8'h77);
    rd(16'h2F, 8'h77, "R13 new value after");
    wr(16'h2E, 8'hAA);
    wr(16'h2E, mKey);
    rdwr(16'h2E, mKey, 8'hFF, "R13 read during second key");
    chk("R3 opened by concurrent write", cfgUnlocked, 1);
    rdwr(16'h2E, 8'hAA, 8'h25, "R13 read during exit");
    chk("R6 closed", cfgUnlocked, 0);
    chkOutputs("final");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule